// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block sits between a CPU bus and a tile-based video controller. The CPU sees eight byte-wide registers, chosen by a 3-bit select. Through them it sets control and mask bytes and the two scroll values. It loads a 14-bit video memory pointer and moves bytes to and from video memory through that pointer, which steps forward after every data access. It also reads a status byte and fills a 256-byte sprite attribute memory.

The scroll register and the address register share one first/second write toggle, and a status read clears it. Data reads return a buffered byte that is one access old. Writes that fall in the palette region go to an internal 32-entry palette instead of the video memory port. A write to the backdrop entry is copied into all eight slots whose low two index bits are zero. The renderer reads the palette and the sprite memory through their own read ports.

Top module: `vid_regport`

## Requirements
- R1: After synchronous reset, the following are all zero: the video pointer (`vram_addr`), the write toggle, the read buffer, both scroll values, the control byte, the mask byte, the vertical-blank flag and the sprite pointer.
- R2: The select codes are 0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 address and 7 data. `rdata` is combinational and valid while `cs` is high and `we` is low. Reads of codes other than 2 and 7 return 0, and writes to code 2 are ignored. A write to code 0 sets `ctrl_out` and a write to code 1 sets `mask_out`.
- R3: An address write with the toggle clear sets the pointer to {wdata[5:0], 8'h00}. With the toggle set, it ORs wdata into the low byte. Every scroll or address write flips the toggle.
- R4: A scroll write with the toggle clear sets horizontal scroll. With the toggle set, it sets vertical scroll, and values above 239 become 0. Each scroll value is output as coarse (value >> 3, 5 bits) and fine (value & 7, 3 bits).
- R5: After each data read or data write, the pointer advances by 32 when control bit 2 is 1, and by 1 otherwise. The result wraps modulo 2^14.
- R6: A data read returns the buffer's current content. The buffer then loads `vram_rdata` at the current pointer, and the pointer then advances.
- R7: A status read returns {vblank, status_in[6:0]} and clears both the vertical-blank flag and the toggle. A `vblank_set` pulse sets the flag, and it wins over a status read in the same cycle. The byte returned by that read shows the old flag.
- R8: A data write with the pointer below 14'h3F00 drives `vram_we` with `vram_wdata` = wdata at `vram_addr`. At or above 14'h3F00, `vram_we` stays low.
- R9: A data write at or above 14'h3F00 with pointer bits 3:0 zero stores wdata into palette slots 0, 4, 8, 12, 16, 20, 24 and 28.
- R10: Other palette-region writes store to slot pointer[4:0] only when pointer bits 1:0 are nonzero. When they are zero, the palette is unchanged.
- R11: A sprite-data write stores wdata at the 8-bit sprite pointer, and the pointer then advances by one, wrapping from 255 to 0. A sprite-pointer write loads the pointer. `spr_rdata` appears one clock after `spr_raddr`.
- R12: `pal_rdata` is the palette slot selected by `pal_raddr`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 write, 0 read |
| rsel | input | 3 | Register select |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data (combinational) |
| vblank_set | input | 1 | Pulse that sets the vertical-blank flag |
| status_in | input | 7 | Low status bits supplied by the renderer |
| ctrl_out | output | 8 | Control byte |
| mask_out | output | 8 | Mask byte |
| hscroll_coarse | output | 5 | Horizontal scroll, tile part |
| hscroll_fine | output | 3 | Horizontal scroll, pixel part |
| vscroll_coarse | output | 5 | Vertical scroll, tile part |
| vscroll_fine | output | 3 | Vertical scroll, pixel part |
| vram_addr | output | 14 | Video memory pointer |
| vram_we | output | 1 | Video memory write strobe |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory read data at vram_addr |
| pal_raddr | input | 5 | Palette read index |
| pal_rdata | output | 8 | Palette read data |
| spr_raddr | input | 8 | Sprite memory read address |
| spr_rdata | output | 8 | Sprite memory read data, one cycle later |

## Verification
The address and scroll registers are each swept over all 256 first-write values with a paired second write. This separates the high-byte masking and the toggle flip, and it shows that the clamp acts only above 239. Data reads from a preloaded pattern show the one-access delay of the buffer. Runs with the step set to 1 and to 32 near the top of the 14-bit space show the wrap. A sequential fill of the whole palette region, followed by an alias write and a write to an ignored slot, separates mirrored, direct and dropped palette writes, and shows that `vram_we` stays low there. A full 256-byte sprite fill followed by one more write shows the pointer wrap. Status reads placed between single address writes, and one read given in the same cycle as a `vblank_set` pulse, show the clearing of the toggle and the priority of the set.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [2:0] {
    RS_CTRL   = 3'd0,
    RS_MASK   = 3'd1,
    RS_STAT   = 3'd2,
    RS_SPTR   = 3'd3,
    RS_SDATA  = 3'd4,
    RS_SCROLL = 3'd5,
    RS_ADDR   = 3'd6,
    RS_DATA   = 3'd7
  } rsel_e;

  localparam int CTRL_STEP_BIT = 2;
endpackage

// File: rtl/vrp_addr_scroll.sv
module vrp_addr_scroll #(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int STEP_WIDE   = 32,
  parameter int VSCROLL_MAX = 239
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_scroll,
  input  logic              wr_addr,
  input  logic              clr_toggle,
  input  logic              step,
  input  logic              step_wide,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] vaddr,
  output logic [DATA_W-1:0] hscroll,
  output logic [DATA_W-1:0] vscroll
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] INC_WIDE = ADDR_W'(STEP_WIDE);
  localparam logic [ADDR_W-1:0] INC_ONE  = ADDR_W'(1);
  localparam logic [DATA_W-1:0] VMAX     = DATA_W'(VSCROLL_MAX);

  logic toggle;
  logic [ADDR_W-1:0] inc;

  assign inc = step_wide ? INC_WIDE : INC_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle  <= 1'b0;
      vaddr   <= '0;
      hscroll <= '0;
      vscroll <= '0;
    end else begin
      if (clr_toggle) toggle <= 1'b0;
      if (wr_scroll) begin
        if (!toggle) hscroll <= wdata;
        else         vscroll <= (wdata > VMAX) ? '0 : wdata;
        toggle <= ~toggle;
      end
      if (wr_addr) begin
        if (!toggle) vaddr <= {wdata[HI_W-1:0], {DATA_W{1'b0}}};
        else         vaddr <= vaddr | {{HI_W{1'b0}}, wdata};
        toggle <= ~toggle;
      end
      if (step) vaddr <= vaddr + inc;
    end
  end

  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_scroll || wr_addr) |=> (toggle != $past(toggle)));
  assert_toggle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_toggle && !wr_scroll && !wr_addr) |=> !toggle);
  assert_vclamp_R4: assert property (@(posedge clk) disable iff (rst)
    vscroll <= VMAX);
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_addr) |=> (vaddr - $past(vaddr)) == (($past(step_wide)) ? INC_WIDE : INC_ONE));
endmodule

// File: rtl/vrp_palette.sv
module vrp_palette #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              mirror,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int N = 1 << IDX_W;

  logic [DATA_W-1:0] pal [N];
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    assign hit[i] = mirror ? (IDX[1:0] == 2'b00) : (widx == IDX);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (we && hit[i]) pal[i] <= wdata;
    end
  end

  assign rdata = pal[ridx];

  assert_mirror_R9: assert property (@(posedge clk) disable iff (rst)
    (we && mirror) |=> (pal[0] == $past(wdata)) && (pal[N-4] == $past(wdata)));
  assert_hits_R10: assert property (@(posedge clk) disable iff (rst)
    (we && !mirror) |-> $onehot0(hit));
endmodule

// File: rtl/vrp_sprite_mem.sv
module vrp_sprite_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ptr,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (set_ptr) ptr <= wdata[AW-1:0];
    else if (wr_data) ptr <= ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_data) mem[ptr] <= wdata;
    rdata <= mem[raddr];
  end

  assert_ptr_inc_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !set_ptr) |=> (ptr == $past(ptr) + AW'(1)));
endmodule

// File: rtl/vid_regport.sv
module vid_regport
  import vrp_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int PAL_IDX_W   = 5,
  parameter int SPR_AW      = 8,
  parameter int STEP_WIDE   = 32,
  parameter int VSCROLL_MAX = 239,
  parameter int PAL_BASE    = 16'h3F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [2:0]        rsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              vblank_set,
  input  logic [DATA_W-2:0] status_in,
  output logic [DATA_W-1:0] ctrl_out,
  output logic [DATA_W-1:0] mask_out,
  output logic [DATA_W-4:0] hscroll_coarse,
  output logic [2:0]        hscroll_fine,
  output logic [DATA_W-4:0] vscroll_coarse,
  output logic [2:0]        vscroll_fine,
  output logic [ADDR_W-1:0] vram_addr,
  output logic              vram_we,
  output logic [DATA_W-1:0] vram_wdata,
  input  logic [DATA_W-1:0] vram_rdata,
  input  logic [PAL_IDX_W-1:0] pal_raddr,
  output logic [DATA_W-1:0] pal_rdata,
  input  logic [SPR_AW-1:0] spr_raddr,
  output logic [DATA_W-1:0] spr_rdata
);
  localparam logic [ADDR_W-1:0] PAL_START = ADDR_W'(PAL_BASE);

  rsel_e rs;
  logic wr, rd;
  logic data_wr, data_rd, stat_rd;
  logic in_pal, pal_mirror, pal_we;
  logic vblank;
  logic [DATA_W-1:0] rbuf, hscroll, vscroll;
  logic [ADDR_W-1:0] vaddr;

  assign rs      = rsel_e'(rsel);
  assign wr      = cs & we;
  assign rd      = cs & ~we;
  assign data_wr = wr && (rs == RS_DATA);
  assign data_rd = rd && (rs == RS_DATA);
  assign stat_rd = rd && (rs == RS_STAT);

  vrp_addr_scroll #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STEP_WIDE(STEP_WIDE), .VSCROLL_MAX(VSCROLL_MAX)
  ) u_addr (
    .clk(clk), .rst(rst),
    .wr_scroll(wr && (rs == RS_SCROLL)),
    .wr_addr(wr && (rs == RS_ADDR)),
    .clr_toggle(stat_rd),
    .step(data_wr | data_rd),
    .step_wide(ctrl_out[CTRL_STEP_BIT]),
    .wdata(wdata),
    .vaddr(vaddr),
    .hscroll(hscroll),
    .vscroll(vscroll)
  );

  assign in_pal     = (vaddr >= PAL_START);
  assign pal_mirror = (vaddr[3:0] == 4'h0);
  assign pal_we     = data_wr && in_pal && (pal_mirror || (vaddr[1:0] != 2'b00));

  vrp_palette #(.DATA_W(DATA_W), .IDX_W(PAL_IDX_W)) u_pal (
    .clk(clk), .rst(rst),
    .we(pal_we), .mirror(pal_mirror),
    .widx(vaddr[PAL_IDX_W-1:0]), .wdata(wdata),
    .ridx(pal_raddr), .rdata(pal_rdata)
  );

  vrp_sprite_mem #(.DATA_W(DATA_W), .AW(SPR_AW)) u_spr (
    .clk(clk), .rst(rst),
    .set_ptr(wr && (rs == RS_SPTR)),
    .wr_data(wr && (rs == RS_SDATA)),
    .wdata(wdata),
    .raddr(spr_raddr), .rdata(spr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_out <= '0;
      mask_out <= '0;
      vblank   <= 1'b0;
      rbuf     <= '0;
    end else begin
      if (wr && (rs == RS_CTRL)) ctrl_out <= wdata;
      if (wr && (rs == RS_MASK)) mask_out <= wdata;
      if (vblank_set)   vblank <= 1'b1;
      else if (stat_rd) vblank <= 1'b0;
      if (data_rd) rbuf <= vram_rdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (stat_rd)      rdata = {vblank, status_in};
    else if (data_rd) rdata = rbuf;
  end

  assign vram_addr      = vaddr;
  assign vram_we        = data_wr && !in_pal;
  assign vram_wdata     = wdata;
  assign hscroll_coarse = hscroll[DATA_W-1:3];
  assign hscroll_fine   = hscroll[2:0];
  assign vscroll_coarse = vscroll[DATA_W-1:3];
  assign vscroll_fine   = vscroll[2:0];

  assert_vblank_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !vblank_set) |=> !vblank);
  assert_vblank_set_R7: assert property (@(posedge clk) disable iff (rst)
    vblank_set |=> vblank);
  assert_rbuf_fill_R6: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> (rbuf == $past(vram_rdata)));
  assert_vram_guard_R8: assert property (@(posedge clk) disable iff (rst)
    vram_we |-> (vram_addr < PAL_START) && cs && we);
endmodule

// File: tb/sim_vid_regport.sv
module sim_vid_regport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, we = 1'b0;
  logic [2:0] rsel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic vblank_set = 1'b0;
  logic [6:0] status_in = 7'h15;
  logic [7:0] ctrl_out, mask_out;
  logic [4:0] hscroll_coarse, vscroll_coarse;
  logic [2:0] hscroll_fine, vscroll_fine;
  logic [13:0] vram_addr;
  logic vram_we;
  logic [7:0] vram_wdata, vram_rdata;
  logic [4:0] pal_raddr = '0;
  logic [7:0] pal_rdata;
  logic [7:0] spr_raddr = '0;
  logic [7:0] spr_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] vmem [2048];
  logic [7:0] emem [2048];
  logic [7:0] epal [32];
  logic [7:0] ebuf;
  logic [13:0] eaddr;
  logic wide;

  always #2 clk = ~clk;

  vid_regport u0 (.*);

  assign vram_rdata = vmem[vram_addr[10:0]];
  always @(posedge clk) if (vram_we) vmem[vram_addr[10:0]] <= vram_wdata;

  function automatic logic [7:0] pat(input logic [10:0] a);
    return a[7:0] ^ 8'hA5 ^ {5'b0, a[10:8]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    cs = 1; we = 1; rsel = r; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] r, output logic [7:0] d);
    @(negedge clk);
    cs = 1; we = 0; rsel = r;
    #1 d = rdata;
    @(negedge clk);
    cs = 0;
  endtask

  task automatic set_addr(input logic [13:0] a);
    logic [7:0] s;
    rd(3'd2, s);
    wr(3'd6, {2'b00, a[13:8]});
    wr(3'd6, a[7:0]);
    eaddr = a;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    wr(3'd0, c);
    wide = c[2];
  endtask

  task automatic bump();
    eaddr = eaddr + (wide ? 14'd32 : 14'd1);
  endtask

  task automatic data_read(input string req);
    logic [7:0] d;
    rd(3'd7, d);
    chk(req, d, ebuf);
    ebuf = emem[eaddr[10:0]];
    bump();
  endtask

  task automatic data_write(input logic [7:0] d);
    if (eaddr < 14'h3F00) emem[eaddr[10:0]] = d;
    else if (eaddr[3:0] == 4'h0) begin
      for (int k = 0; k < 32; k += 4) epal[k] = d;
    end else if (eaddr[1:0] != 2'b00) epal[eaddr[4:0]] = d;
    wr(3'd7, d);
    bump();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 2048; i++) begin
      vmem[i] = pat(11'(i));
      emem[i] = pat(11'(i));
    end
    ebuf = 8'h00; eaddr = '0; wide = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 addr", vram_addr, 14'h0);
    chk("R1 scroll", {hscroll_coarse, hscroll_fine, vscroll_coarse, vscroll_fine}, 16'h0);
    chk("R1 ctrl/mask", {ctrl_out, mask_out}, 16'h0);
    rd(3'd2, d);
    chk("R1 vblank", d, {1'b0, 7'h15});
    data_read("R1 R6 first buffer zero");
    chk("R5 step one", vram_addr, 14'h1);
    data_read("R6 delayed byte");

    // R2 decode
    wr(3'd0, 8'h5A); chk("R2 ctrl", ctrl_out, 8'h5A);
    wr(3'd1, 8'h1E); chk("R2 mask", mask_out, 8'h1E);
    set_ctrl(8'h00);
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R2 status write ignored", d, {1'b0, 7'h15});
    foreach (d[i]) begin end
    for (int r = 0; r < 7; r++) begin
      if (r != 2) begin
        rd(3'(r), d);
        chk("R2 unused read zero", d, 8'h00);
      end
    end

    // R3 address sweep
    for (int h = 0; h < 256; h++) begin
      rd(3'd2, d);
      wr(3'd6, 8'(h));
      chk("R3 high write", vram_addr, {6'(h), 8'h00});
      wr(3'd6, 8'(h) ^ 8'h3C);
      chk("R3 low write", vram_addr, {6'(h), 8'(h) ^ 8'h3C});
    end

    // R4 scroll sweep
    rd(3'd2, d);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] hx, vx;
      hx = 8'(v) ^ 8'h5A;
      vx = (v > 239) ? 8'h00 : 8'(v);
      wr(3'd5, hx);
      wr(3'd5, 8'(v));
      chk("R4 horizontal", {hscroll_coarse, hscroll_fine}, hx);
      chk("R4 vertical clamp", {vscroll_coarse, vscroll_fine}, vx);
    end

    // R7 toggle cleared by status read
    rd(3'd2, d);
    wr(3'd6, 8'h12);
    rd(3'd2, d);
    wr(3'd6, 8'h05);
    chk("R7 toggle cleared", vram_addr, 14'h0500);
    wr(3'd6, 8'h81);
    chk("R7 toggle second", vram_addr, 14'h0581);

    // R7 vblank set and clear
    @(negedge clk); vblank_set = 1; @(negedge clk); vblank_set = 0;
    status_in = 7'h6B;
    rd(3'd2, d); chk("R7 vblank seen", d, 8'hEB);
    rd(3'd2, d); chk("R7 vblank cleared", d, 8'h6B);
    @(negedge clk);
    cs = 1; we = 0; rsel = 3'd2; vblank_set = 1;
    #1 d = rdata;
    @(negedge clk); cs = 0; vblank_set = 0;
    chk("R7 same-cycle old flag", d, 8'h6B);
    rd(3'd2, d); chk("R7 set wins", d, 8'hEB);

    // R6 R8 writes then buffered reads, step 1
    set_addr(14'h0100);
    for (int i = 0; i < 6; i++) data_write(8'hC0 + 8'(i));
    chk("R5 addr after writes", vram_addr, 14'h0106);
    for (int i = 0; i < 6; i++) chk("R8 vram written", vmem[11'h100 + 11'(i)], emem[11'h100 + 11'(i)]);
    set_addr(14'h0100);
    for (int i = 0; i < 8; i++) data_read("R6 buffered stream");

    // R5 wide step and wrap
    set_ctrl(8'h04);
    set_addr(14'h0040);
    data_read("R6 wide read");
    chk("R5 step 32", vram_addr, 14'h0060);
    data_read("R6 wide read 2");
    set_addr(14'h3FF1);
    data_read("R6 top read");
    chk("R5 wrap 32", vram_addr, 14'h0011);
    set_ctrl(8'h00);
    set_addr(14'h3FFF);
    data_read("R6 top read 2");
    chk("R5 wrap 1", vram_addr, 14'h0000);

    // R9 R10 palette fill
    set_addr(14'h3F00);
    for (int i = 0; i < 32; i++) data_write(8'h40 + 8'(i));
    chk("R8 no vram write in palette", vmem[11'h700], pat(11'h700));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); pal_raddr = 5'(i); #1;
      chk("R9 R10 R12 palette", pal_rdata, epal[i]);
    end
    data_write(8'h9D);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); pal_raddr = 5'(i); #1;
      chk("R9 alias mirror", pal_rdata, epal[i]);
    end
    set_addr(14'h3F04);
    data_write(8'hEE);
    set_addr(14'h3F1C);
    data_write(8'hEF);
    @(negedge clk); pal_raddr = 5'd4; #1;
    chk("R10 ignored slot 4", pal_rdata, 8'h9D);
    @(negedge clk); pal_raddr = 5'd28; #1;
    chk("R10 ignored slot 28", pal_rdata, 8'h9D);
    set_addr(14'h3F05);
    data_write(8'h77);
    @(negedge clk); pal_raddr = 5'd5; #1;
    chk("R10 direct slot 5", pal_rdata, 8'h77);

    // R11 sprite memory
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'hAA); wr(3'd4, 8'hBB); wr(3'd4, 8'hCC);
    @(negedge clk); spr_raddr = 8'hFE; @(negedge clk);
    chk("R11 sprite fe", spr_rdata, 8'hAA);
    spr_raddr = 8'hFF; @(negedge clk);
    chk("R11 sprite ff", spr_rdata, 8'hBB);
    spr_raddr = 8'h00; @(negedge clk);
    chk("R11 sprite wrap", spr_rdata, 8'hCC);
    wr(3'd3, 8'h00);
    for (int i = 0; i < 256; i++) wr(3'd4, 8'(i) ^ 8'h33);
    wr(3'd4, 8'h77);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); spr_raddr = 8'(i); @(negedge clk);
      chk("R11 sprite fill", spr_rdata, (i == 0) ? 8'h77 : (8'(i) ^ 8'h33));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule